// File: doc/BRIEF.md
# Multi-line receive FIFO with deferred interrupt

This block is the receive side of a sixteen-line serial multiplexer. The line receivers hand it one character per cycle, tagged with the line number and with parity and framing error flags. A modem monitor hands it carrier-detect changes. Every character and every change becomes an entry in one shared first-in first-out store. Software reads the oldest entry as a 16-bit word and pops it in the same access. The top bit of that word is the valid flag, so an entry that is present reads as a negative number.

The block does not interrupt on every character. A programmable timeout selects one of three policies. The value 0 means no timer. The value 1 means an interrupt on every character. A value from 2 to 255 means an interrupt a number of milliseconds after the first character arrives in an empty store. A three-quarter-full alarm and any status record request the interrupt at once, whatever the timeout. A master-clear self-test empties the store, fills it with eight diagnostic records and then reports pass or fail.

Top module: `mux_rx_silo`

## Requirements
- R1: After reset, rd_word reads 0 (valid bit [15] clear), and irq, mclr_busy and diag_fail are all 0.
- R2: A data entry reads as [15]=1, [14]=overrun, [13]=framing error, [12]=parity error, [11:8]=line, [7:0]=character. Entries read oldest first. A cycle with rd_en high removes the oldest entry. An empty store reads [15]=0.
- R3: A status record has [14:12]=111. A modem record has [7]=0 and the carrier level in [0]. A diagnostic record has [7]=1 and its code in [6:0]. Storing any status record requests the interrupt in every timeout mode.
- R4: With timeout 1, storing a data entry requests the interrupt from the next cycle.
- R5: With a timeout T from 2 to 255, the interrupt is requested no earlier than T-1 and no later than T millisecond ticks after the first entry reaches an empty store, plus at most 3 cycles.
- R6: With timeout 0, data entries alone never request the interrupt below the alarm level.
- R7: When 48 of the 64 entries are filled, the interrupt is requested regardless of the timeout.
- R8: irq is high only while cfg_rie is 1. Raising cfg_rie exposes a request that is already pending.
- R9: A write to a full store is dropped. The next stored data entry, and only that one, carries the overrun bit. If that entry also has both framing and parity errors, its parity bit is cleared.
- R10: If a modem change and a character arrive in the same cycle, the modem record is stored and the character is lost and counted as an overrun.
- R11: A mclr_start pulse flushes the store and raises mclr_busy. The block then stores eight diagnostic records with codes 0 to 7 on line 0, reads 0xF080+code, and clears mclr_busy with diag_fail=0. Characters and pops are ignored while mclr_busy is high.
- R12: irq drops in the cycle after the last entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | Received character strobe |
| ch_line | input | 4 | Line number of the character |
| ch_data | input | 8 | Character |
| ch_perr | input | 1 | Parity error on the character |
| ch_ferr | input | 1 | Framing error on the character |
| mdm_valid | input | 1 | Carrier-detect change strobe |
| mdm_line | input | 4 | Line number of the change |
| mdm_dcd | input | 1 | New carrier level |
| cfg_rie | input | 1 | Receive interrupt enable |
| timo_wr | input | 1 | Load strobe for the timeout value |
| timo_val | input | 8 | Timeout value: 0, 1, or milliseconds 2 to 255 |
| mclr_start | input | 1 | Start the master-clear self-test |
| mclr_busy | output | 1 | Self-test in progress |
| diag_fail | output | 1 | Result of the last self-test |
| rd_en | input | 1 | Pop the oldest entry |
| rd_word | output | 16 | Oldest entry, [15] is the valid flag |
| irq | output | 1 | Receive interrupt request |

## Verification
Each timeout policy gets the same single character. With timeout 1 the interrupt must rise at once. With 3 it must stay low in a window and then rise. With 0 it must stay low for many milliseconds, which separates the three policies. Status records sent with timeout 0 show that they bypass the timer. Filling to 47 and then 48 entries brackets the alarm threshold. Overfilling to 65 shows that the extra write is dropped and that the overrun marker lands on exactly one later entry. A simultaneous modem change and character exercise the collision rule. A self-test started on a store that still holds data shows the flush, the ignored input and the eight diagnostic codes in order.

// File: rtl/rxsilo_pkg.sv
package rxsilo_pkg;
  localparam int unsigned LINE_W = 4;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned ENT_W  = 3 + LINE_W + CHAR_W;

  typedef logic [ENT_W-1:0] entry_t;

  function automatic entry_t pack_data(input logic ovr, input logic fe, input logic pe,
                                       input logic [LINE_W-1:0] ln,
                                       input logic [CHAR_W-1:0] ch);
    return {ovr, fe, pe, ln, ch};
  endfunction

  function automatic entry_t pack_stat(input logic [LINE_W-1:0] ln, input logic diag,
                                       input logic [CHAR_W-2:0] val);
    return {3'b111, ln, diag, val};
  endfunction
endpackage

// File: rtl/rxsilo_fifo.sv
module rxsilo_fifo #(
  parameter int unsigned W     = 15,
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [AW:0]   cnt_q, cnt_n;
  logic          wr_ok, rd_ok;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign count = cnt_q;
  assign rdata = mem[rp_q];

  always_comb begin
    wr_ok = wr & ~full & ~flush;
    rd_ok = rd & ~empty & ~flush;
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (wr_ok) wp_n = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_n = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  // R2
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));

  // R2
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr) |=> empty);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd && !flush) |=> full);
endmodule

// File: rtl/rxsilo_timer.sv
module rxsilo_timer #(
  parameter int unsigned TICK_DIV = 250000,
  parameter int unsigned TW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timo,
  input  logic          start,
  input  logic          clear,
  output logic          expire
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q, pre_n;
  logic [TW-1:0] ms_q, ms_n;
  logic          run_q, run_n;
  logic          exp_q, exp_n;
  logic          tick;

  assign tick   = (pre_q == PW'(TICK_DIV-1));
  assign expire = exp_q;

  always_comb begin
    pre_n = tick ? '0 : pre_q + 1'b1;
    exp_n = run_q & ~clear & (timo >= TW'(2)) & (ms_q == timo);
    run_n = run_q;
    ms_n  = ms_q;
    if (clear) begin
      run_n = 1'b0;
      ms_n  = '0;
    end else if (start) begin
      run_n = 1'b1;
      ms_n  = '0;
    end else if (run_q) begin
      if (exp_n) run_n = 1'b0;
      else if (tick) ms_n = ms_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      pre_q <= pre_n;
      ms_q  <= ms_n;
      run_q <= run_n;
      exp_q <= exp_n;
    end
  end

  // R5
  timo_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exp_q) |-> $past(timo) >= TW'(2));

  // R5
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |=> !exp_q);
endmodule

// File: rtl/rxsilo_selftest.sv
module rxsilo_selftest #(
  parameter int unsigned NCODES = 8,
  parameter int unsigned CW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          wr,
  output logic [CW-1:0] code,
  output logic          done
);
  localparam int unsigned IW = (NCODES > 1) ? $clog2(NCODES) : 1;

  logic          busy_q, busy_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          last;

  assign last = (idx_q == IW'(NCODES-1));
  assign busy = busy_q;
  assign wr   = busy_q;
  assign code = CW'(idx_q);
  assign done = busy_q & last;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    if (start) begin
      busy_n = 1'b1;
      idx_n  = '0;
    end else if (busy_q) begin
      if (last) busy_n = 1'b0;
      else      idx_n  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
    end
  end

  // R11
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= IW'(NCODES-1)));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
  import rxsilo_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned TICK_DIV = 250000,
  parameter int unsigned NDIAG    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_valid,
  input  logic [LINE_W-1:0] ch_line,
  input  logic [CHAR_W-1:0] ch_data,
  input  logic              ch_perr,
  input  logic              ch_ferr,
  input  logic              mdm_valid,
  input  logic [LINE_W-1:0] mdm_line,
  input  logic              mdm_dcd,
  input  logic              cfg_rie,
  input  logic              timo_wr,
  input  logic [7:0]        timo_val,
  input  logic              mclr_start,
  output logic              mclr_busy,
  output logic              diag_fail,
  input  logic              rd_en,
  output logic [15:0]       rd_word,
  output logic              irq
);
  localparam int unsigned CNT_W     = $clog2(DEPTH) + 1;
  localparam int unsigned ALARM_LVL = (DEPTH * 3) / 4;

  logic [CNT_W-1:0] count;
  logic             empty, full, alarm;
  entry_t           rdata, wdata;
  logic             wr, wr_ok, is_stat, is_data, lost, pop, flush, accept;
  logic             st_busy, st_wr, st_done;
  logic [6:0]       st_code;
  logic             expire, tmr_start, tmr_clear, trig;
  logic [7:0]       timo_q, timo_n;
  logic             ovr_q, ovr_n, latch_q, latch_n;
  logic             chk_q, chk_n, fail_q, fail_n;

  assign accept = ~st_busy & ~chk_q & ~mclr_start;
  assign flush  = mclr_start & ~st_busy & ~chk_q;
  assign pop    = rd_en & accept;
  assign alarm  = (count >= CNT_W'(ALARM_LVL));

  rxsilo_fifo #(.W(ENT_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr(wr), .wdata(wdata),
    .rd(pop), .rdata(rdata), .count(count), .empty(empty), .full(full));

  rxsilo_timer #(.TICK_DIV(TICK_DIV), .TW(8)) i_timer (
    .clk(clk), .rst_n(rst_n), .timo(timo_q), .start(tmr_start),
    .clear(tmr_clear), .expire(expire));

  rxsilo_selftest #(.NCODES(NDIAG), .CW(7)) i_selftest (
    .clk(clk), .rst_n(rst_n), .start(flush), .busy(st_busy), .wr(st_wr),
    .code(st_code), .done(st_done));

  // entry selection: self-test, then modem record, then character
  always_comb begin
    wr      = 1'b0;
    wdata   = '0;
    is_stat = 1'b0;
    is_data = 1'b0;
    lost    = 1'b0;
    if (st_wr) begin
      wr      = 1'b1;
      is_stat = 1'b1;
      wdata   = pack_stat('0, 1'b1, st_code);
    end else if (accept) begin
      if (mdm_valid) begin
        wr      = 1'b1;
        is_stat = 1'b1;
        lost    = ch_valid;
        wdata   = pack_stat(mdm_line, 1'b0, {6'b0, mdm_dcd});
      end else if (ch_valid) begin
        wr      = 1'b1;
        is_data = 1'b1;
        wdata   = pack_data(ovr_q, ch_ferr, ch_perr & ~(ovr_q & ch_ferr), ch_line, ch_data);
      end
    end
    wr_ok = wr & ~full;
  end

  // next state: overrun marker, interrupt latch, timeout, self-test result
  always_comb begin
    tmr_start = wr_ok & empty;
    tmr_clear = flush | (empty & ~wr_ok);
    trig      = (wr_ok & (is_stat | (is_data & (timo_q == 8'd1)))) | expire;
    timo_n    = timo_wr ? timo_val : timo_q;

    if (flush)                   ovr_n = 1'b0;
    else if (lost | (wr & full)) ovr_n = 1'b1;
    else if (is_data & wr_ok)    ovr_n = 1'b0;
    else                         ovr_n = ovr_q;

    if (flush)      latch_n = 1'b0;
    else if (trig)  latch_n = 1'b1;
    else if (empty) latch_n = 1'b0;
    else            latch_n = latch_q;

    chk_n  = st_done;
    if (flush)      fail_n = 1'b0;
    else if (chk_q) fail_n = (count != CNT_W'(NDIAG));
    else            fail_n = fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timo_q  <= '0;
      ovr_q   <= 1'b0;
      latch_q <= 1'b0;
      chk_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      timo_q  <= timo_n;
      ovr_q   <= ovr_n;
      latch_q <= latch_n;
      chk_q   <= chk_n;
      fail_q  <= fail_n;
    end
  end

  assign rd_word   = empty ? 16'h0000 : {1'b1, rdata};
  assign irq       = cfg_rie & ~empty & (latch_q | alarm);
  assign mclr_busy = st_busy | chk_q;
  assign diag_fail = fail_q;

  // R9
  drop_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !st_wr) |=> ovr_q);

  // R10
  collide_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mdm_valid && ch_valid) |=> ovr_q);

  // R3
  status_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && is_stat) |=> latch_q);

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count <= CNT_W'(1)) && mclr_busy);
endmodule

// File: tb/test_mux_rx_silo.sv
module test_mux_rx_silo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ch_valid, ch_perr, ch_ferr, mdm_valid, mdm_dcd;
  logic [3:0]  ch_line, mdm_line;
  logic [7:0]  ch_data, timo_val;
  logic        cfg_rie, timo_wr, mclr_start, rd_en;
  logic        mclr_busy, diag_fail, irq;
  logic [15:0] rd_word;
  int          total = 0;
  int          bad = 0;

  localparam int unsigned MS = 10;

  always #2 clk = ~clk;

  mux_rx_silo #(.DEPTH(64), .TICK_DIV(MS), .NDIAG(8)) i_mux_rx_silo (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_line(ch_line),
    .ch_data(ch_data), .ch_perr(ch_perr), .ch_ferr(ch_ferr),
    .mdm_valid(mdm_valid), .mdm_line(mdm_line), .mdm_dcd(mdm_dcd),
    .cfg_rie(cfg_rie), .timo_wr(timo_wr), .timo_val(timo_val),
    .mclr_start(mclr_start), .mclr_busy(mclr_busy), .diag_fail(diag_fail),
    .rd_en(rd_en), .rd_word(rd_word), .irq(irq));

  task automatic check(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_timo(input logic [7:0] v);
    timo_val = v; timo_wr = 1'b1;
    @(negedge clk);
    timo_wr = 1'b0;
  endtask

  task automatic send_ch(input logic [3:0] ln, input logic [7:0] d, input logic pe,
                         input logic fe);
    ch_valid = 1'b1; ch_line = ln; ch_data = d; ch_perr = pe; ch_ferr = fe;
    @(negedge clk);
    ch_valid = 1'b0; ch_perr = 1'b0; ch_ferr = 1'b0;
  endtask

  task automatic pop_chk(input logic [15:0] exp, input string req);
    check(rd_word == exp, req, rd_word, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    check(rd_word == 16'h0, "R1 word", rd_word, 16'h0);
    check({irq, mclr_busy, diag_fail} == 3'b0, "R1 flags",
          {13'b0, irq, mclr_busy, diag_fail}, 16'h0);
  endtask

  task automatic t_format;
    set_timo(8'd0); cfg_rie = 1'b0;
    send_ch(4'd5, 8'hA5, 1'b1, 1'b0);
    send_ch(4'd12, 8'h3C, 1'b0, 1'b1);
    pop_chk(16'h95A5, "R2 first entry");
    pop_chk(16'hAC3C, "R2 second entry");
    check(rd_word[15] == 1'b0, "R2 empty", rd_word, 16'h0);
  endtask

  task automatic t_immediate;
    set_timo(8'd1); cfg_rie = 1'b0;
    send_ch(4'd1, 8'h41, 1'b0, 1'b0);
    check(irq == 1'b0, "R8 masked", {15'b0, irq}, 16'h0);
    cfg_rie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R4 R8 unmasked", {15'b0, irq}, 16'h1);
    pop_chk(16'h8141, "R4 entry");
    check(irq == 1'b0, "R12 drop", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_window;
    set_timo(8'd3); cfg_rie = 1'b1;
    send_ch(4'd7, 8'h77, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    check(irq == 1'b0, "R5 early", {15'b0, irq}, 16'h0);
    repeat (13) @(negedge clk);
    check(irq == 1'b1, "R5 due", {15'b0, irq}, 16'h1);
    pop_chk(16'h8777, "R5 entry");
    check(irq == 1'b0, "R12 drop", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_notimer;
    set_timo(8'd0); cfg_rie = 1'b1;
    send_ch(4'd2, 8'h22, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    check(irq == 1'b0, "R6 no timer", {15'b0, irq}, 16'h0);
    pop_chk(16'h8222, "R6 entry");
  endtask

  task automatic t_alarm;
    set_timo(8'd0); cfg_rie = 1'b1;
    for (int i = 0; i < 47; i++) send_ch(4'd4, 8'(i), 1'b0, 1'b0);
    check(irq == 1'b0, "R7 below", {15'b0, irq}, 16'h0);
    send_ch(4'd4, 8'd47, 1'b0, 1'b0);
    check(irq == 1'b1, "R7 at level", {15'b0, irq}, 16'h1);
    for (int i = 0; i < 48; i++) begin
      rd_en = 1'b1; @(negedge clk);
    end
    rd_en = 1'b0;
    check(irq == 1'b0, "R12 drained", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_overflow;
    int errs;
    set_timo(8'd0); cfg_rie = 1'b0;
    for (int i = 0; i < 64; i++) send_ch(4'd6, 8'(i), 1'b0, 1'b0);
    send_ch(4'd6, 8'hEE, 1'b0, 1'b0);
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      if (rd_word != {8'h86, 8'(i)}) errs++;
      rd_en = 1'b1; @(negedge clk);
    end
    rd_en = 1'b0;
    check(errs == 0, "R9 kept 64 in order", 16'(errs), 16'h0);
    check(rd_word[15] == 1'b0, "R9 extra dropped", rd_word, 16'h0);
    send_ch(4'd3, 8'h55, 1'b1, 1'b1);
    send_ch(4'd3, 8'h56, 1'b0, 1'b0);
    pop_chk(16'hE355, "R9 overrun marked, parity cleared");
    pop_chk(16'h8356, "R9 marker once");
  endtask

  task automatic t_collide;
    set_timo(8'd0); cfg_rie = 1'b1;
    mdm_valid = 1'b1; mdm_line = 4'd9; mdm_dcd = 1'b1;
    ch_valid = 1'b1; ch_line = 4'd2; ch_data = 8'h11;
    @(negedge clk);
    mdm_valid = 1'b0; ch_valid = 1'b0;
    check(irq == 1'b1, "R3 modem request", {15'b0, irq}, 16'h1);
    pop_chk(16'hF901, "R3 R10 modem record");
    check(rd_word[15] == 1'b0, "R10 char lost", rd_word, 16'h0);
    send_ch(4'd2, 8'h12, 1'b0, 1'b0);
    pop_chk(16'hC212, "R10 overrun");
  endtask

  task automatic t_selftest;
    int n;
    set_timo(8'd0); cfg_rie = 1'b0;
    send_ch(4'd8, 8'h88, 1'b0, 1'b0);
    send_ch(4'd8, 8'h89, 1'b0, 1'b0);
    mclr_start = 1'b1; @(negedge clk); mclr_start = 1'b0;
    check(mclr_busy == 1'b1, "R11 busy", {15'b0, mclr_busy}, 16'h1);
    send_ch(4'd1, 8'hBB, 1'b0, 1'b0);
    n = 0;
    while (mclr_busy && n < 50) begin @(negedge clk); n++; end
    check(mclr_busy == 1'b0, "R11 finished", {15'b0, mclr_busy}, 16'h0);
    check(diag_fail == 1'b0, "R11 pass", {15'b0, diag_fail}, 16'h0);
    for (int i = 0; i < 8; i++) pop_chk(16'hF080 + 16'(i), "R11 code");
    check(rd_word[15] == 1'b0, "R11 flushed and input ignored", rd_word, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ch_valid = 0; ch_line = 0; ch_data = 0; ch_perr = 0; ch_ferr = 0;
    mdm_valid = 0; mdm_line = 0; mdm_dcd = 0;
    cfg_rie = 0; timo_wr = 0; timo_val = 0; mclr_start = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_format;
    t_immediate;
    t_window;
    t_notimer;
    t_alarm;
    t_overflow;
    t_collide;
    t_selftest;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule